// File: doc/BRIEF.md
# Read/Write Beat Arbiter with Priority Layers

This block sits inside a bus-to-memory bridge. A single memory port is shared by the read and write paths, and every cycle this block decides which of the two pending beats gets the port. Its output is one select bit, where 1 means the write beat is served and 0 means the read beat is served. The bridge presents the chosen beat downstream with a shared valid/ready handshake and feeds that handshake back to the arbiter.

When both sides are pending, the arbiter applies its rules in a fixed order. The higher QoS value wins first. Next, a lone final write beat wins over a read that is part of a longer burst. Next, a write burst already under way wins, followed by a read burst already under way. If no rule decides, the select flips from its previous value. After a choice has been presented and is stalled (valid high, ready low), it is frozen until that handshake completes. A static strict mode makes writes win whenever both sides are pending. This removes the circular wait that arises when clusters read from each other's memories while writing into their own.

The select output is combinational from the current requests and the stored state, so a choice takes effect in the cycle it is made. The previous select and the lock flag are registered.

Top module: `rw_beat_arbiter`

## Requirements
- R1: After reset the stored select is read (0) and the lock is clear, so an idle first cycle shows select 0.
- R2: When exactly one of the read and write requests is pending and no lock is held, the select names that side (1 for write, 0 for read).
- R3: When both are pending, strict mode is off and no lock is held, the side with the numerically larger QoS value is selected.
- R4: With equal QoS, a write flagged as last beat is selected over a read not flagged as last beat.
- R5: If R4 does not decide, a nonzero outstanding write-beat count selects write; otherwise a nonzero outstanding read-beat count selects read.
- R6: If none of R3 to R5 decides, the select is the inverse of the previous cycle's select.
- R7: A cycle with handshake valid high and ready low freezes the select. It holds its value in every following cycle, up to and including the cycle in which valid and ready are both high, whatever the requests do.
- R8: With strict mode on, no lock held and both sides pending, write is selected regardless of QoS, last flags and counts.
- R9: With no request pending and no lock held, the select keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strict_wr_i | input | 1 | Static mode: writes always win when both pending |
| wr_pend_i | input | 1 | A write beat is pending |
| rd_pend_i | input | 1 | A read beat is pending |
| wr_qos_i | input | QOS_W | QoS of the pending write |
| rd_qos_i | input | QOS_W | QoS of the pending read |
| wr_last_i | input | 1 | Pending write is the final beat of its burst |
| rd_last_i | input | 1 | Pending read is the final beat of its burst |
| wr_left_i | input | CNT_W | Write beats still outstanding in an ongoing burst |
| rd_left_i | input | CNT_W | Read beats still outstanding in an ongoing burst |
| hs_valid_i | input | 1 | Downstream handshake valid |
| hs_ready_i | input | 1 | Downstream handshake ready |
| sel_wr_o | output | 1 | Select: 1 = write, 0 = read |

## Verification
The select is driven with one side pending alone, with both pending under unequal QoS in each direction, and with equal QoS under each tie-break layer in turn. These patterns tell whether each layer fires only when the layers above it leave a tie. Runs of full ties with zero counts show the alternation. An idle gap shows that the previous choice is kept. A stalled handshake is followed by requests that favour the other side, which separates a true freeze from a re-arbitration. Strict mode is tried against a read with higher QoS and a read burst in progress.

// File: rtl/rw_beat_arbiter.sv
module rw_beat_arbiter #(
  parameter int QOS_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strict_wr_i,
  input  logic             wr_pend_i,
  input  logic             rd_pend_i,
  input  logic [QOS_W-1:0] wr_qos_i,
  input  logic [QOS_W-1:0] rd_qos_i,
  input  logic             wr_last_i,
  input  logic             rd_last_i,
  input  logic [CNT_W-1:0] wr_left_i,
  input  logic [CNT_W-1:0] rd_left_i,
  input  logic             hs_valid_i,
  input  logic             hs_ready_i,
  output logic             sel_wr_o
);

  logic sel_q, lock_q;
  logic pick, lock_d;

  wire both    = wr_pend_i & rd_pend_i;
  wire stalled = hs_valid_i & ~hs_ready_i;
  wire fired   = hs_valid_i & hs_ready_i;

  always_comb begin
    pick = sel_q;
    if (wr_pend_i ^ rd_pend_i)               pick = wr_pend_i;
    else if (both && strict_wr_i)            pick = 1'b1;
    else if (both) begin
      if (wr_qos_i > rd_qos_i)               pick = 1'b1;
      else if (rd_qos_i > wr_qos_i)          pick = 1'b0;
      else if (wr_last_i && !rd_last_i)      pick = 1'b1;
      else if (wr_left_i != '0)              pick = 1'b1;
      else if (rd_left_i != '0)              pick = 1'b0;
      else                                   pick = ~sel_q;
    end
  end

  assign sel_wr_o = lock_q ? sel_q : pick;
  assign lock_d   = lock_q ? ~fired : stalled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      sel_q  <= sel_wr_o;
      lock_q <= lock_d;
    end
  end

  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  // R7
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(hs_valid_i && !hs_ready_i)) |-> sel_wr_o == $past(sel_wr_o));

  // R2
  lone_side_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && (wr_pend_i ^ rd_pend_i)) |-> sel_wr_o == wr_pend_i);

  // R8
  strict_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && strict_wr_i && wr_pend_i && rd_pend_i) |-> sel_wr_o);

  // R3
  qos_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && !strict_wr_i && wr_pend_i && rd_pend_i && wr_qos_i != rd_qos_i)
      |-> sel_wr_o == (wr_qos_i > rd_qos_i));

  // R9
  idle_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(lock_q) && !lock_q && !wr_pend_i && !rd_pend_i)
      |-> sel_wr_o == $past(sel_wr_o));

endmodule

// File: tb/test_rw_beat_arbiter.sv
module test_rw_beat_arbiter;
  localparam int QW = 4;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic strict_wr = 0, wr_pend = 0, rd_pend = 0, wr_last = 0, rd_last = 0;
  logic hs_valid = 0, hs_ready = 0;
  logic [QW-1:0] wr_qos = 0, rd_qos = 0;
  logic [CW-1:0] wr_left = 0, rd_left = 0;
  logic sel_wr;

  always #4 clk = ~clk;

  rw_beat_arbiter #(.QOS_W(QW), .CNT_W(CW)) i_rw_beat_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .strict_wr_i(strict_wr),
    .wr_pend_i(wr_pend), .rd_pend_i(rd_pend), .wr_qos_i(wr_qos), .rd_qos_i(rd_qos),
    .wr_last_i(wr_last), .rd_last_i(rd_last), .wr_left_i(wr_left), .rd_left_i(rd_left),
    .hs_valid_i(hs_valid), .hs_ready_i(hs_ready), .sel_wr_o(sel_wr));

  int checks = 0, errors = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit m_sel = 0, m_lock = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (sel_wr !== e) begin
        errors++;
        $display("FAIL %s: sel_wr=%0b expected %0b", t, sel_wr, e);
      end
    end
  end

  task automatic step(bit wp, bit rp, int wq, int rq, bit wl, bit rl,
                      int wc, int rc, bit av, bit ar, bit st, string tag);
    bit e;
    @(posedge clk); #1;
    wr_pend = wp; rd_pend = rp; wr_qos = wq[QW-1:0]; rd_qos = rq[QW-1:0];
    wr_last = wl; rd_last = rl; wr_left = wc[CW-1:0]; rd_left = rc[CW-1:0];
    hs_valid = av; hs_ready = ar; strict_wr = st;
    if (m_lock) e = m_sel;
    else if (wp != rp) e = wp;
    else if (!wp) e = m_sel;
    else if (st) e = 1;
    else if (wq != rq) e = (wq > rq);
    else if (wl && !rl) e = 1;
    else if (wc != 0) e = 1;
    else if (rc != 0) e = 0;
    else e = !m_sel;
    if (m_lock) begin if (av && ar) m_lock = 0; end
    else if (av && !ar) m_lock = 1;
    m_sel = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step(0,0,0,0,0,0,0,0,0,0,0,"R1 idle after reset");
    step(1,0,0,0,1,0,0,0,1,1,0,"R2 write alone");
    step(0,1,0,0,0,1,0,0,1,1,0,"R2 read alone");
    step(0,0,0,0,0,0,0,0,0,0,0,"R9 idle keeps read");
    step(1,0,0,0,1,0,0,0,1,1,0,"R2 write alone again");
    step(0,0,0,0,0,0,0,0,0,0,0,"R9 idle keeps write");
    step(1,1,5,2,0,1,0,3,1,1,0,"R3 write higher qos");
    step(1,1,1,7,1,0,4,0,1,1,0,"R3 read higher qos");
    step(1,1,3,3,1,0,0,5,1,1,0,"R4 last write over read burst");
    step(1,1,3,3,0,0,2,6,1,1,0,"R5 write burst ongoing");
    step(1,1,3,3,1,1,0,6,1,1,0,"R5 read burst ongoing");
    step(1,1,3,3,1,1,0,0,1,1,0,"R6 toggle to write");
    step(1,1,3,3,0,0,0,0,1,1,0,"R6 toggle to read");
    step(1,1,3,3,1,1,0,0,1,1,0,"R6 toggle to write again");
    step(0,1,0,0,0,1,0,0,1,0,0,"R7 stall on read");
    step(1,0,0,0,1,0,0,0,1,0,0,"R7 held while stalled");
    step(1,1,9,0,1,0,2,0,1,0,0,"R7 held vs high write qos");
    step(1,0,0,0,1,0,0,0,1,1,0,"R7 held in completing cycle");
    step(1,0,0,0,1,0,0,0,1,1,0,"R7 free after completion");
    step(1,1,0,9,0,1,0,4,1,1,1,"R8 strict beats read qos");
    step(1,1,2,2,0,0,0,0,1,1,1,"R8 strict no toggle");
    step(0,1,0,0,0,1,0,0,1,1,1,"R2 read alone in strict");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: done=0 expected 1");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule